// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Current and Saved Level Masks

The block gathers a set of level-sensitive interrupt request lines. Each line has a programmable 4-bit priority level. The block presents to the processor core the highest priority level that is pending and allowed through, and it answers acknowledge cycles with a vector number. The vector is a programmable base plus the index of the winning source. A software acknowledge read returns the same vector through the register bus and has no other effect.

Two mask registers support nested service routines. A hardware acknowledge copies the current level mask into the saved level mask. In the same clock edge it raises the current mask to the acknowledged level, so that only strictly higher levels can interrupt the running routine. Software later writes the saved value back into the current mask, or writes any other level to probe pending requests. Requests are never cleared by the block; a line stays pending until its peripheral drops it.

Register map, as offsets on `regAddr`:

| Offset | Contents |
|---|---|
| 0 to 7 | Level of source 0 to 7 |
| 8 | Current mask |
| 9 | Saved mask |
| 10 | Vector base |
| 11 | Software acknowledge (read-only) |

Top module: `irq_level_mask_ctrl`

## Requirements
- R1: After reset, every source level reads 0, both mask registers read 0xF, the vector base reads 0x40 and `coreLevelOut` is 0.
- R2: A pending source takes part in arbitration only if both of these hold:
  - its level is nonzero;
  - the current mask is 0xF, which means open, or the source's level is strictly greater than the current mask.
- R3: Among the sources that take part, the highest level wins. A tie is won by the lowest source index.
- R4: `coreLevelOut` is a register. After each clock edge it shows the winning level computed from the state and requests present before that edge, or 0 if nothing was allowed through.
- R5: `ackVecOut` equals (vector base + winning index) modulo 256. It is 0x00 when no source is allowed through.
- R6: A hardware acknowledge (`hwAckIn` high at a clock edge) with a winner present does two things at that edge:
  - it copies the current mask into the saved mask;
  - it loads the current mask with the winner's level.
- R7: A hardware acknowledge with no winner leaves both masks unchanged.
- R8: A read of offset 11 returns the same vector as `ackVecOut` and changes no state.
- R9: Writes take `regWrData` at the clock edge:
  - offsets 0 to 7 and 8 to 9 take the low 4 bits, and read back zero-extended;
  - offset 10 takes all 8 bits.
- R10: Acknowledging a source does not clear its request. Once the mask is lowered again, the source is again presented.
- R11: When `hwAckIn` is high, a bus write to either mask register in the same cycle is dropped. The acknowledge result stands.
- R12: Writes to offsets 11 to 15 change nothing, and reads of offsets 12 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 8 | Level-sensitive request lines, one per source |
| hwAckIn | input | 1 | Hardware acknowledge strobe from the core, one cycle |
| ackVecOut | output | 8 | Vector number for the current winner, 0x00 if none |
| regAddr | input | 4 | Register bus offset |
| regWrEn | input | 1 | Register bus write strobe |
| regWrData | input | 8 | Register bus write data |
| regRdData | output | 8 | Register bus read data for `regAddr` |
| coreLevelOut | output | 4 | Registered winning level presented to the core |

## Verification
The hardest state to reach is a two-deep nest. It needs three things in place:
- a first acknowledge has already raised the mask;
- a higher-level source has arrived and been acknowledged on top of it;
- software then restores the mask while the earlier request is still asserted.

The stimulus builds this in order: it programs levels, raises overlapping requests, acknowledges twice, and writes the saved value back. It also places an acknowledge in the same cycle as a mask write, both with and without a winner present. A long stretch of mixed random writes, requests and acknowledges then runs, with every output compared each clock against a behavioural model.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int LVL_W = 4;
  localparam logic [LVL_W-1:0] MASK_OPEN = 4'hF;

  typedef struct packed {
    logic wrLevel;
    logic wrCurMask;
    logic wrSavedMask;
    logic wrBase;
    logic ackHw;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LEVEL,
    RD_CUR,
    RD_SAVED,
    RD_BASE,
    RD_SWACK
  } rdSel_t;
endpackage

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4,
  parameter int IDX_W   = 3
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              hwAckIn,
  output dpStrobe_t         strb,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  srcSel
);
  localparam int ADDR_CUR   = NUM_SRC;
  localparam int ADDR_SAVED = NUM_SRC + 1;
  localparam int ADDR_BASE  = NUM_SRC + 2;
  localparam int ADDR_SWACK = NUM_SRC + 3;

  int addrVal;

  always_comb begin
    addrVal = int'(regAddr);
    strb = '0;
    strb.ackHw = hwAckIn;
    rdSel = RD_NONE;
    srcSel = regAddr[IDX_W-1:0];
    if (addrVal < NUM_SRC) begin
      rdSel = RD_LEVEL;
      strb.wrLevel = regWrEn;
    end else if (addrVal == ADDR_CUR) begin
      rdSel = RD_CUR;
      // an acknowledge owns the mask registers for its cycle
      strb.wrCurMask = regWrEn && !hwAckIn;
    end else if (addrVal == ADDR_SAVED) begin
      rdSel = RD_SAVED;
      strb.wrSavedMask = regWrEn && !hwAckIn;
    end else if (addrVal == ADDR_BASE) begin
      rdSel = RD_BASE;
      strb.wrBase = regWrEn;
    end else if (addrVal == ADDR_SWACK) begin
      rdSel = RD_SWACK;
    end
  end
endmodule

// File: rtl/irq_lvl_dp.sv
module irq_lvl_dp
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int VEC_W   = 8,
  parameter logic [VEC_W-1:0] BASE_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  dpStrobe_t         strb,
  input  rdSel_t            rdSel,
  input  logic [IDX_W-1:0]  srcSel,
  input  logic [VEC_W-1:0]  regWrData,
  output logic [LVL_W-1:0]  coreLevelOut,
  output logic [VEC_W-1:0]  ackVecOut,
  output logic [VEC_W-1:0]  regRdData
);
  logic [LVL_W-1:0] srcLvl [NUM_SRC];
  logic [LVL_W-1:0] curMask, savedMask, coreLvlQ;
  logic [VEC_W-1:0] vecBase;
  logic [NUM_SRC-1:0] permit;
  logic             winValid;
  logic [IDX_W-1:0] winIdx;
  logic [LVL_W-1:0] winLvl;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign permit[g] = reqIn[g] && (srcLvl[g] != '0) &&
                       ((curMask == MASK_OPEN) || (srcLvl[g] > curMask));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) srcLvl[g] <= '0;
      else if (strb.wrLevel && (int'(srcSel) == g)) srcLvl[g] <= regWrData[LVL_W-1:0];
    end
  end

  // highest level wins; strict compare keeps the lowest index on ties
  always_comb begin
    winValid = 1'b0;
    winIdx = '0;
    winLvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (permit[i] && (!winValid || srcLvl[i] > winLvl)) begin
        winValid = 1'b1;
        winIdx = IDX_W'(i);
        winLvl = srcLvl[i];
      end
    end
  end

  assign ackVecOut = winValid ? vecBase + VEC_W'(winIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMask   <= MASK_OPEN;
      savedMask <= MASK_OPEN;
    end else if (strb.ackHw) begin
      if (winValid) begin
        savedMask <= curMask;
        curMask   <= winLvl;
      end
    end else begin
      if (strb.wrCurMask)   curMask   <= regWrData[LVL_W-1:0];
      if (strb.wrSavedMask) savedMask <= regWrData[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecBase  <= BASE_RST;
      coreLvlQ <= '0;
    end else begin
      if (strb.wrBase) vecBase <= regWrData;
      coreLvlQ <= winValid ? winLvl : '0;
    end
  end

  assign coreLevelOut = coreLvlQ;

  always_comb begin
    unique case (rdSel)
      RD_LEVEL: regRdData = VEC_W'(srcLvl[srcSel]);
      RD_CUR:   regRdData = VEC_W'(curMask);
      RD_SAVED: regRdData = VEC_W'(savedMask);
      RD_BASE:  regRdData = vecBase;
      RD_SWACK: regRdData = ackVecOut;
      default:  regRdData = '0;
    endcase
  end

  AST_ACK_SAVES_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackHw && winValid |=> savedMask == $past(curMask)); // R6
  AST_ACK_RAISES_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackHw && winValid |=> curMask == $past(winLvl)); // R6
  AST_EMPTY_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackHw && !winValid |=> $stable(curMask) && $stable(savedMask)); // R7
  AST_LEVEL_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    coreLvlQ != '0 |-> ($past(curMask) == MASK_OPEN || coreLvlQ > $past(curMask))); // R2
  AST_WINNER_PERMITTED: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> permit[winIdx]); // R3
endmodule

// File: rtl/irq_level_mask_ctrl.sv
module irq_level_mask_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4,
  parameter int VEC_W   = 8,
  parameter logic [VEC_W-1:0] BASE_RST = 8'h40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               hwAckIn,
  output logic [VEC_W-1:0]   ackVecOut,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [VEC_W-1:0]   regWrData,
  output logic [VEC_W-1:0]   regRdData,
  output logic [LVL_W-1:0]   coreLevelOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  dpStrobe_t        strb;
  rdSel_t           rdSel;
  logic [IDX_W-1:0] srcSel;

  irq_lvl_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .hwAckIn (hwAckIn),
    .strb    (strb),
    .rdSel   (rdSel),
    .srcSel  (srcSel)
  );

  irq_lvl_dp #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .BASE_RST(BASE_RST)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .strb         (strb),
    .rdSel        (rdSel),
    .srcSel       (srcSel),
    .regWrData    (regWrData),
    .coreLevelOut (coreLevelOut),
    .ackVecOut    (ackVecOut),
    .regRdData    (regRdData)
  );
endmodule

// File: tb/irq_level_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_mask_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       hwAckIn = 1'b0;
  logic [7:0] ackVecOut;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [3:0] coreLevelOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  int mLv[8];
  int mCm, mSm, mBase, mExp;

  always #2.5 clk = ~clk;

  irq_level_mask_ctrl u_irq_level_mask_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .hwAckIn(hwAckIn), .ackVecOut(ackVecOut),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .coreLevelOut(coreLevelOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void modelWin(output int idx, output int lvl);
    idx = -1;
    lvl = 0;
    for (int i = 0; i < 8; i++)
      if (reqIn[i] && mLv[i] != 0 && (mCm == 15 || mLv[i] > mCm) && (idx < 0 || mLv[i] > lvl)) begin
        idx = i;
        lvl = mLv[i];
      end
  endfunction

  function automatic int modelVec();
    int wi, wl;
    modelWin(wi, wl);
    return (wi < 0) ? 0 : ((mBase + wi) % 256);
  endfunction

  function automatic int modelRead(input int a);
    if (a < 8) return mLv[a];
    if (a == 8) return mCm;
    if (a == 9) return mSm;
    if (a == 10) return mBase;
    if (a == 11) return modelVec();
    return 0;
  endfunction

  // behavioural reference, updated at each clock edge
  always @(posedge clk or negedge rstN) begin : p_model
    int wi, wl;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mLv[i] = 0;
      mCm = 15; mSm = 15; mBase = 64; mExp = 0;
    end else begin
      modelWin(wi, wl);
      mExp = (wi < 0) ? 0 : wl;
      if (hwAckIn && wi >= 0) begin
        mSm = mCm;
        mCm = wl;
      end
      if (regWrEn) begin
        if (regAddr < 8) mLv[regAddr] = int'(regWrData[3:0]);
        else if (regAddr == 8 && !hwAckIn) mCm = int'(regWrData[3:0]);
        else if (regAddr == 9 && !hwAckIn) mSm = int'(regWrData[3:0]);
        else if (regAddr == 10) mBase = int'(regWrData);
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      #2;
      chk("R4 level", int'(coreLevelOut), mExp);
      chk("R5 vector", int'(ackVecOut), modelVec());
      chk(regAddr == 11 ? "R8 swack read" : "R9 read", int'(regRdData), modelRead(int'(regAddr)));
    end
  end

  task automatic step(input logic [7:0] r, input logic we, input logic [3:0] a,
                      input logic [7:0] d, input logic ak);
    reqIn = r; regWrEn = we; regAddr = a; regWrData = d; hwAckIn = ak;
    @(negedge clk);
    #1;
  endtask

  initial begin : p_watchdog
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : p_stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    step(8'h00, 0, 4'd8, 8'h00, 0);
    chk("R1 cur mask", int'(regRdData), 15);
    chk("R1 level out", int'(coreLevelOut), 0);
    step(8'h00, 0, 4'd9, 8'h00, 0);
    chk("R1 saved mask", int'(regRdData), 15);
    step(8'h00, 0, 4'd10, 8'h00, 0);
    chk("R1 base", int'(regRdData), 64);
    step(8'h00, 0, 4'd3, 8'h00, 0);
    chk("R1 source level", int'(regRdData), 0);
    // R9 programming
    step(8'h00, 1, 4'd0, 8'hF3, 0);
    chk("R9 low nibble kept", int'(regRdData), 3);
    step(8'h00, 1, 4'd1, 8'h05, 0);
    step(8'h00, 1, 4'd2, 8'h05, 0);
    step(8'h00, 1, 4'd5, 8'h02, 0);
    step(8'h00, 1, 4'd10, 8'h20, 0);
    chk("R9 base write", int'(regRdData), 32);
    // R3 tie at level 5 goes to source 1, R8 swack read
    step(8'h27, 0, 4'd11, 8'h00, 0);
    chk("R3 tie winner vector", int'(regRdData), 8'h21);
    chk("R4 level one clock later", int'(coreLevelOut), 5);
    // R6 first acknowledge
    step(8'h27, 0, 4'd8, 8'h00, 1);
    chk("R6 cur raised", int'(regRdData), 5);
    step(8'h27, 0, 4'd9, 8'h00, 0);
    chk("R6 saved holds old", int'(regRdData), 15);
    chk("R2 equal level blocked", int'(coreLevelOut), 0);
    chk("R5 none pending vector", int'(ackVecOut), 0);
    // R2 strictly higher passes
    step(8'h27, 1, 4'd3, 8'h07, 0);
    step(8'h2F, 0, 4'd11, 8'h00, 0);
    chk("R8 swack vector", int'(regRdData), 8'h23);
    step(8'h2F, 0, 4'd8, 8'h00, 0);
    chk("R2 higher level passes", int'(coreLevelOut), 7);
    chk("R8 no mask change", int'(regRdData), 5);
    // R6 nested acknowledge
    step(8'h2F, 0, 4'd9, 8'h00, 1);
    chk("R6 nested saved", int'(regRdData), 5);
    // R7 + R11 empty acknowledge with a mask write
    step(8'h2F, 1, 4'd8, 8'h0F, 1);
    chk("R11 write dropped on empty ack", int'(regRdData), 7);
    step(8'h2F, 0, 4'd9, 8'h00, 0);
    chk("R7 saved unchanged", int'(regRdData), 5);
    // R10 restore from saved, request still pending
    step(8'h2F, 1, 4'd8, 8'h05, 0);
    step(8'h2F, 0, 4'd8, 8'h00, 0);
    chk("R10 request still presented", int'(coreLevelOut), 7);
    // R11 ack with winner beats mask write
    step(8'h2F, 1, 4'd8, 8'h0F, 0);
    step(8'h2F, 1, 4'd8, 8'h02, 1);
    chk("R11 ack result stands", int'(regRdData), 7);
    // R12 read-only and unmapped offsets
    step(8'h2F, 1, 4'd11, 8'h55, 0);
    step(8'h2F, 1, 4'd12, 8'h66, 0);
    chk("R12 unmapped reads zero", int'(regRdData), 0);
    step(8'h2F, 0, 4'd10, 8'h00, 0);
    chk("R12 base untouched", int'(regRdData), 32);
    step(8'h2F, 0, 4'd8, 8'h00, 0);
    chk("R12 cur untouched", int'(regRdData), 7);
    // R2 level zero never presented
    step(8'h10, 1, 4'd8, 8'h0F, 0);
    step(8'h10, 0, 4'd8, 8'h00, 0);
    chk("R2 zero level ignored", int'(coreLevelOut), 0);
    // mixed random traffic, compared every clock
    for (int n = 0; n < 600; n++) begin
      step(8'($urandom), ($urandom % 3) == 0, 4'($urandom), 8'($urandom), ($urandom % 5) == 0);
    end
    done = 1;
    #1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule